// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block is the interrupt status unit of a 16550-style UART register file. It holds the four interrupt enables and the FIFO-enable flag, and the line-status and modem-status registers with their sticky bits. From these it derives the interrupt identification value and a level interrupt request. Four sources are ranked in a fixed order, and only the highest-ranked source that is both pending and enabled is reported.

The surrounding register file sends in single-cycle event pulses: line errors and modem-line deltas. It also sends the receive-ready and transmit-empty levels, register writes for the enable bits and the FIFO flag, and read strobes for the two status registers. A read strobe returns the current status byte on the same cycle and clears that register's sticky bits at the following edge. All register state and the identification value change on the same clock edge that samples the input that caused them.

Top module: `uart_irq_id`

## Requirements
- R1: After reset the identification output reads 0x01, `irq` is low, all four enables and the FIFO flag are zero, and the sticky error bits (status bits 4:1) and modem delta bits (modem bits 3:0) are zero.
- R2: Sources are ranked from highest to lowest: line status, data available, transmit holding empty, modem status. The identification low nibble is 0x6, 0x4, 0x2 and 0x0 for these sources. It is 0x1 when no source is pending and enabled. Bits 5:4 read 0.
- R3: A line-status interrupt is pending when any of status bits 4:1 (overrun, parity, framing, break, set by `err_set[0..3]`) is 1 and enable bit 2 is set.
- R4: A data-available interrupt is pending when status bit 0 (registered `rx_ready`) is 1 and enable bit 0 is set. A transmit-holding-empty interrupt is pending when status bit 5 (registered `thr_empty`) is 1 and enable bit 1 is set. Status bit 6 is registered `tx_idle` and bit 7 reads 0.
- R5: A modem-status interrupt is pending when any of modem bits 3:0 (set by `delta_set`) is 1 and enable bit 3 is set. Modem bits 7:4 are the registered `modem_lines`.
- R6: Identification bits 7:6 read 11 while the FIFO flag is set and 00 while it is clear.
- R7: `irq` changes only on an edge where the identification low nibble changes. It then goes high if a source is pending and enabled and low if none is.
- R8: While `lsr_rd` is high, `lsr_rdata` shows the current status byte. At the next edge status bits 4:1 clear. Bits 0, 5 and 6 keep following their inputs.
- R9: While `msr_rd` is high, `msr_rdata` shows the current modem byte. At the next edge modem bits 3:0 clear and bits 7:4 are unaffected.
- R10: An error or delta event that arrives in the same cycle as a read strobe of its register is kept set, not lost.
- R11: A change of enables, FIFO flag, status or modem state, including a read side effect, shows in the identification value and `irq` right after the edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Write strobe for the enable bits |
| ier_wdata | input | 4 | Enables: 0 data avail, 1 tx empty, 2 line status, 3 modem |
| fifo_wr | input | 1 | Write strobe for the FIFO-enable flag |
| fifo_wdata | input | 1 | New FIFO-enable flag |
| rx_ready | input | 1 | Receive data ready level |
| thr_empty | input | 1 | Transmit holding register empty level |
| tx_idle | input | 1 | Transmitter fully idle level |
| err_set | input | 4 | Pulses: overrun, parity, framing, break |
| delta_set | input | 4 | Pulses setting modem delta bits 3:0 |
| modem_lines | input | 4 | Modem input line levels |
| lsr_rd | input | 1 | Line-status read strobe |
| msr_rd | input | 1 | Modem-status read strobe |
| lsr_rdata | output | 8 | Current line-status byte |
| msr_rdata | output | 8 | Current modem-status byte |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Level interrupt request |

## Verification
Every input, including the read strobes, is taken at one rising edge. The status bytes, the identification value and `irq` all change at that edge, with no further pipeline stage. The read data is combinational from state and so already holds the pre-clear value in the strobe cycle. The bench drives at the falling edge and advances its behavioural model with the same inputs. It compares every output at the next falling edge, one edge later, so each result is sampled half a period after the edge on which it is due.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int NUM_SRC  = 4;
    localparam int BYTE_W   = 8;
    localparam int NUM_ERR  = 4;
    localparam int NUM_DLT  = 4;
    localparam int ID_W     = 3;
    localparam int SEL_W    = $clog2(NUM_SRC);

    // status byte positions
    localparam int LS_READY = 0;
    localparam int LS_ERR0  = 1;
    localparam int LS_THRE  = 5;
    localparam int LS_IDLE  = 6;

    // enable positions
    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    // source index, index 0 ranks highest
    localparam int SRC_LS = 0;
    localparam int SRC_RX = 1;
    localparam int SRC_TX = 2;
    localparam int SRC_MS = 3;

    typedef struct packed {
        logic [BYTE_W-1:0]  lsr;
        logic [BYTE_W-1:0]  msr;
        logic [NUM_SRC-1:0] ier;
        logic               fifo;
    } src_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] iir;
        logic              irq;
    } id_state_t;
endpackage

// File: rtl/uart_irq_src_regs.sv
module uart_irq_src_regs
    import uart_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ier_wr,
    input  logic [NUM_SRC-1:0]  ier_wdata,
    input  logic                fifo_wr,
    input  logic                fifo_wdata,
    input  logic                rx_ready,
    input  logic                thr_empty,
    input  logic                tx_idle,
    input  logic [NUM_ERR-1:0]  err_set,
    input  logic [NUM_DLT-1:0]  delta_set,
    input  logic [NUM_DLT-1:0]  modem_lines,
    input  logic                lsr_rd,
    input  logic                msr_rd,
    output logic [BYTE_W-1:0]   lsr_q,
    output logic [BYTE_W-1:0]   msr_q,
    output logic                fifo_q,
    output logic                fifo_d,
    output logic [NUM_SRC-1:0]  pend_d
);
    localparam int ERR_HI = LS_ERR0 + NUM_ERR - 1;

    src_state_t st_d, st_q;
    logic [NUM_ERR-1:0] err_keep;
    logic [NUM_DLT-1:0] dlt_keep;

    always_comb begin
        st_d     = st_q;
        err_keep = lsr_rd ? '0 : st_q.lsr[ERR_HI:LS_ERR0];
        dlt_keep = msr_rd ? '0 : st_q.msr[NUM_DLT-1:0];
        if (ier_wr)  st_d.ier  = ier_wdata;
        if (fifo_wr) st_d.fifo = fifo_wdata;
        st_d.lsr                   = '0;
        st_d.lsr[LS_READY]         = rx_ready;
        st_d.lsr[ERR_HI:LS_ERR0]   = err_keep | err_set;
        st_d.lsr[LS_THRE]          = thr_empty;
        st_d.lsr[LS_IDLE]          = tx_idle;
        st_d.msr[NUM_DLT-1:0]      = dlt_keep | delta_set;
        st_d.msr[BYTE_W-1:NUM_DLT] = modem_lines;

        pend_d         = '0;
        pend_d[SRC_LS] = (|st_d.lsr[ERR_HI:LS_ERR0]) & st_d.ier[EN_LS];
        pend_d[SRC_RX] = st_d.lsr[LS_READY] & st_d.ier[EN_RX];
        pend_d[SRC_TX] = st_d.lsr[LS_THRE]  & st_d.ier[EN_TX];
        pend_d[SRC_MS] = (|st_d.msr[NUM_DLT-1:0]) & st_d.ier[EN_MS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lsr_q  = st_q.lsr;
    assign msr_q  = st_q.msr;
    assign fifo_q = st_q.fifo;
    assign fifo_d = st_d.fifo;

    // R8: a status read without new errors leaves the error bits clear
    assert_lsr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && err_set == '0) |=> (lsr_q[ERR_HI:LS_ERR0] == '0));

    // R9: a modem read without new deltas leaves the delta bits clear
    assert_msr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && delta_set == '0) |=> (msr_q[NUM_DLT-1:0] == '0));

    // R10: an arriving event is never dropped, even under a read
    assert_err_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_set != '0) |=> ((lsr_q[ERR_HI:LS_ERR0] & $past(err_set)) == $past(err_set)));

    assert_dlt_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (delta_set != '0) |=> ((msr_q[NUM_DLT-1:0] & $past(delta_set)) == $past(delta_set)));
endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] grant,
    output logic [ID_W-1:0]    id,
    output logic               any
);
    logic [SEL_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i]) sel = SEL_W'(i);
        end
        any   = |pend;
        grant = any ? (NUM_SRC'(1) << sel) : '0;
        id    = ID_W'(NUM_SRC - 1) - ID_W'(sel);
    end
endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ier_wr,
    input  logic [3:0] ier_wdata,
    input  logic       fifo_wr,
    input  logic       fifo_wdata,
    input  logic       rx_ready,
    input  logic       thr_empty,
    input  logic       tx_idle,
    input  logic [3:0] err_set,
    input  logic [3:0] delta_set,
    input  logic [3:0] modem_lines,
    input  logic       lsr_rd,
    input  logic       msr_rd,
    output logic [7:0] lsr_rdata,
    output logic [7:0] msr_rdata,
    output logic [7:0] iir,
    output logic       irq
);
    localparam int NIB_W = ID_W + 1;

    logic               fifo_q, fifo_d;
    logic [NUM_SRC-1:0] pend_d, grant;
    logic [ID_W-1:0]    id;
    logic               any;
    id_state_t          id_d, id_q;

    uart_irq_src_regs u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .ier_wr      (ier_wr),
        .ier_wdata   (ier_wdata),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata),
        .rx_ready    (rx_ready),
        .thr_empty   (thr_empty),
        .tx_idle     (tx_idle),
        .err_set     (err_set),
        .delta_set   (delta_set),
        .modem_lines (modem_lines),
        .lsr_rd      (lsr_rd),
        .msr_rd      (msr_rd),
        .lsr_q       (lsr_rdata),
        .msr_q       (msr_rdata),
        .fifo_q      (fifo_q),
        .fifo_d      (fifo_d),
        .pend_d      (pend_d)
    );

    uart_irq_prio_enc u_enc (
        .pend  (pend_d),
        .grant (grant),
        .id    (id),
        .any   (any)
    );

    always_comb begin
        id_d = id_q;
        id_d.iir = '0;
        id_d.iir[NIB_W-1:0] = any ? {id, 1'b0} : NIB_W'(1);
        id_d.iir[BYTE_W-1:BYTE_W-2] = {2{fifo_d}};
        if (id_d.iir[NIB_W-1:0] != id_q.iir[NIB_W-1:0])
            id_d.irq = any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q.iir <= BYTE_W'(1);
            id_q.irq <= 1'b0;
        end else begin
            id_q <= id_d;
        end
    end

    assign iir = id_q.iir;
    assign irq = id_q.irq;

    // R2: at most one source is granted
    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: the request line moves only with the identification nibble
    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(iir[NIB_W-1:0]) |-> $stable(irq));

    // R7: request level agrees with the pending flag of the identification
    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iir[0]);

    // R6: top bits mirror the FIFO flag held in the source registers
    assert_fifo_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iir[BYTE_W-1:BYTE_W-2] == {2{fifo_q}});
endmodule

// File: tb/uart_irq_id_tb_top.sv
module uart_irq_id_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ier_wr = 0, fifo_wr = 0, fifo_wdata = 0;
    logic [3:0] ier_wdata = 0;
    logic       rx_ready = 0, thr_empty = 0, tx_idle = 0;
    logic [3:0] err_set = 0, delta_set = 0, modem_lines = 0;
    logic       lsr_rd = 0, msr_rd = 0;
    logic [7:0] lsr_rdata, msr_rdata, iir;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int m_ier = 0, m_fifo = 0, m_err = 0, m_dlt = 0;
    int m_rdy = 0, m_thre = 0, m_idle = 0, m_lines = 0;
    int m_iir = 1, m_irq = 0;

    always #10 clk = ~clk;

    uart_irq_id dut_i (
        .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .rx_ready(rx_ready),
        .thr_empty(thr_empty), .tx_idle(tx_idle), .err_set(err_set),
        .delta_set(delta_set), .modem_lines(modem_lines), .lsr_rd(lsr_rd),
        .msr_rd(msr_rd), .lsr_rdata(lsr_rdata), .msr_rdata(msr_rdata),
        .iir(iir), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int exp_lsr();
        return m_rdy | (m_err << 1) | (m_thre << 5) | (m_idle << 6);
    endfunction

    function automatic int exp_msr();
        return m_dlt | (m_lines << 4);
    endfunction

    task automatic model_advance();
        int low;
        if (ier_wr) m_ier = int'(ier_wdata);
        if (fifo_wr) m_fifo = int'(fifo_wdata);
        m_err = (lsr_rd ? 0 : m_err) | int'(err_set);
        m_dlt = (msr_rd ? 0 : m_dlt) | int'(delta_set);
        m_rdy = int'(rx_ready); m_thre = int'(thr_empty);
        m_idle = int'(tx_idle); m_lines = int'(modem_lines);
        if (m_err != 0 && m_ier[2]) low = 6;
        else if (m_rdy != 0 && m_ier[0]) low = 4;
        else if (m_thre != 0 && m_ier[1]) low = 2;
        else if (m_dlt != 0 && m_ier[3]) low = 0;
        else low = 1;
        if (low != (m_iir & 15)) m_irq = (low == 1) ? 0 : 1;
        m_iir = low | (m_fifo != 0 ? 8'hC0 : 0);
    endtask

    // apply the currently driven inputs at one edge, compare half a period later
    task automatic tick();
        model_advance();
        @(negedge clk);
        chk("R2 iir", int'(iir), m_iir);
        chk("R7 irq", int'(irq), m_irq);
        chk("R8 lsr", int'(lsr_rdata), exp_lsr());
        chk("R9 msr", int'(msr_rdata), exp_msr());
        ier_wr = 0; fifo_wr = 0; err_set = 0; delta_set = 0;
        lsr_rd = 0; msr_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset iir", int'(iir), 1);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset lsr", int'(lsr_rdata), 0);
        chk("R1 reset msr", int'(msr_rdata), 0);
        rst_n = 1;
        @(negedge clk);

        // R3 line status: error pulse, then enable
        err_set = 4'b0100; tick();
        chk("R3 masked", int'(iir), 1);
        ier_wr = 1; ier_wdata = 4'h4; tick();
        chk("R3 pending", int'(iir), 6);
        chk("R11 irq up", int'(irq), 1);

        // R2 priority: all sources present, line status wins
        ier_wr = 1; ier_wdata = 4'hF; rx_ready = 1; thr_empty = 1; delta_set = 4'h1; tick();
        chk("R2 top rank", int'(iir), 6);
        // R8/R11 read clears errors, data available takes over after the edge
        lsr_rd = 1;
        #1 chk("R8 read value", int'(lsr_rdata), 8'h29);
        tick();
        chk("R11 after lsr read", int'(iir), 4);
        chk("R8 bits kept", int'(lsr_rdata), 8'h21);
        rx_ready = 0; tick();
        chk("R4 thr empty", int'(iir), 2);
        thr_empty = 0; tick();
        chk("R5 modem", int'(iir), 0);
        chk("R7 irq held high", int'(irq), 1);
        // R10 read and delta in same cycle keeps new delta
        msr_rd = 1; delta_set = 4'h2; modem_lines = 4'hA; tick();
        chk("R10 delta kept", int'(msr_rdata), 8'hA2);
        msr_rd = 1; tick();
        chk("R9 cleared", int'(msr_rdata), 8'hA0);
        chk("R7 irq low", int'(irq), 0);
        // R10 error under read
        err_set = 4'b1000; lsr_rd = 1; tick();
        chk("R10 err kept", int'(lsr_rdata), 8'h10);
        // R6 FIFO flag
        fifo_wr = 1; fifo_wdata = 1; tick();
        chk("R6 fifo set", int'(iir), 8'hC6);
        fifo_wr = 1; fifo_wdata = 0; lsr_rd = 1; tick();
        chk("R6 fifo clear", int'(iir), 1);
        // R4 data available alone, enable bit 0 only
        ier_wr = 1; ier_wdata = 4'h1; rx_ready = 1; thr_empty = 1; tick();
        chk("R4 data avail", int'(iir), 4);

        // randomised run against the model
        for (int n = 0; n < 3000; n++) begin
            ier_wr = ($urandom_range(0, 7) == 0);
            ier_wdata = 4'($urandom);
            fifo_wr = ($urandom_range(0, 15) == 0);
            fifo_wdata = 1'($urandom);
            rx_ready = 1'($urandom);
            thr_empty = 1'($urandom);
            tx_idle = 1'($urandom);
            err_set = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            delta_set = ($urandom_range(0, 5) == 0) ? 4'($urandom) : 4'h0;
            modem_lines = 4'($urandom);
            lsr_rd = ($urandom_range(0, 3) == 0);
            msr_rd = ($urandom_range(0, 3) == 0);
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule